// File: doc/BRIEF.md
# Non-Maskable Interrupt Edge Acceptor

This block watches a single asynchronous interrupt pin and turns one edge of the chosen polarity into a pending non-maskable request at the top priority level, 16. The pin passes through a synchronizer. A registered copy of the synchronized level lets the block detect an edge. Software picks the active edge with a select bit. Any change of that bit opens a fixed blanking window, and edges that arrive inside the window are thrown away. Without this window, flipping the polarity while the pin sits still could look like an edge.

An edge that clears the blanking window must also pass the acceptance gate. A mask-all bit refuses every request. When mask-all is clear, the request is taken if the override bit is set, if the processor's block bit is clear, or if the device is in a low-power (sleep or standby) state. An accepted edge in a low-power state also raises a one-cycle wake pulse. A rejected edge is lost; it is not remembered for later. The request stays pending until the exception-acknowledge path pulses the clear input. Further edges that arrive while a request is pending fold into that single request. The block has no output for the processor's interrupt mask level, so accepting a request never touches that level.

The control core is a two-state machine. `ST_IDLE` moves to `ST_PENDING` on the transition *take*, which is an accepted, unblanked edge. `ST_PENDING` returns to `ST_IDLE` on the transition *clear*, which is an acknowledge in a cycle with no new take. In every other case, *hold* keeps the current state.

Top module: `nmi_edge_acceptor`

## Requirements
- R1: While a request is pending, `nmi_level` reads 16 and `nmi_req` is 1. Otherwise `nmi_level` reads 0 and `nmi_req` is 0.
- R2: With `edge_rise`=1 only a 0-to-1 pin transition creates a request. With `edge_rise`=0 only a 1-to-0 transition does. A transition in the other direction has no effect.
- R3: A change of `edge_rise` is seen at clock edge e0. Pin edges that would be detected at clock edges e0 through e20 (a pin change driven before e18) are discarded. An edge detected at e21 or later (a pin change driven before e19 or later) is accepted.
- R4: A further change of `edge_rise` inside the blanking window restarts the full 20-cycle window, counted from the new change.
- R5: With `mask_all`=1 no edge is accepted and no wake pulse is produced, whatever the other bits are.
- R6: With `mask_all`=0 and `low_power`=0, an edge is accepted exactly when `bl_override`=1 or `cpu_block`=0.
- R7: With `mask_all`=0 and `low_power`=1, an edge is accepted whatever the values of `cpu_block` and `bl_override`.
- R8: Each edge accepted while `low_power`=1 gives a `wake_pulse` exactly one cycle long, in the same cycle in which the request becomes visible.
- R9: A pending request holds until `ack` is sampled high. It reads 0 one cycle later, unless an accepted edge is detected at that same clock edge, in which case it stays pending.
- R10: Several accepted edges while a request is pending merge into one request. A single acknowledge clears it.
- R11: A pin change driven before clock edge e1 shows on `nmi_req` after edge e3 (three edges of latency). An edge that is rejected or blanked is lost and never produces a request later.
- R12: During and right after reset, `nmi_req`=0, `nmi_level`=0 and `wake_pulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Asynchronous interrupt pin |
| edge_rise | input | 1 | Edge select: 1 = rising, 0 = falling |
| bl_override | input | 1 | Accept even while the processor block bit is set |
| mask_all | input | 1 | Refuse all requests and wake-ups |
| cpu_block | input | 1 | Processor exception block bit |
| low_power | input | 1 | Device is in sleep or standby |
| ack | input | 1 | Clear pulse from the exception-acknowledge path |
| nmi_req | output | 1 | Pending non-maskable request |
| nmi_level | output | LEVEL_W (5) | Priority of the pending request (16) or 0 |
| wake_pulse | output | 1 | One-cycle wake-up strobe |

## Verification
A wrong state register would show up as `nmi_req` and `nmi_level` staying at the wrong value past an acknowledge, or rising with no edge. This is visible within one cycle of the clear or the edge. A blanking counter that reloads to the wrong value, or that does not restart, moves the boundary between the lost and the accepted edge. The bench therefore drives pin changes just before and just after the twentieth cycle, so a counter that is off by one shows up as a missing or an extra request three edges later. Faults in the acceptance gate and the wake logic are exposed by a sweep over all sixteen combinations of the four gating bits, repeated for both polarities.

// File: rtl/nmi_acc_pkg.sv
package nmi_acc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } nmi_state_e;

    localparam int unsigned NMI_PRIORITY = 16;

endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_blank_timer.sv
module nmi_blank_timer #(
    parameter int unsigned BLANK_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    output logic blank
);
    localparam int unsigned CW = $clog2(BLANK_CYCLES + 1);

    logic          sel_q;
    logic [CW-1:0] remain_q;
    logic          sel_moved;

    assign sel_moved = (sel != sel_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            remain_q <= '0;
        end else begin
            sel_q <= sel;
            if (sel_moved)
                remain_q <= CW'(BLANK_CYCLES);
            else if (remain_q != '0)
                remain_q <= remain_q - 1'b1;
        end
    end

    assign blank = sel_moved || (remain_q != '0);
endmodule

// File: rtl/nmi_edge_detect.sv
module nmi_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic rise_sel,
    input  logic blank,
    output logic edge_hit
);
    logic prev_q;
    logic rose_now;
    logic fell_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_in;
    end

    assign rose_now = level_in & ~prev_q;
    assign fell_now = ~level_in & prev_q;
    assign edge_hit = ~blank & (rise_sel ? rose_now : fell_now);
endmodule

// File: rtl/nmi_accept_fsm.sv
module nmi_accept_fsm
    import nmi_acc_pkg::*;
#(
    parameter int unsigned LEVEL_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               edge_hit,
    input  logic               bl_override,
    input  logic               mask_all,
    input  logic               cpu_block,
    input  logic               low_power,
    input  logic               ack,
    output logic               req,
    output logic [LEVEL_W-1:0] level,
    output logic               wake
);
    nmi_state_e state_q, state_d;
    logic       gate_open;
    logic       take;
    logic       wake_q;

    assign gate_open = ~mask_all & (bl_override | ~cpu_block | low_power);
    assign take      = edge_hit & gate_open;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take)        state_d = ST_PENDING;
            ST_PENDING: if (ack && !take) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= take & low_power;
        end
    end

    always_comb begin
        req   = 1'b0;
        level = '0;
        unique case (state_q)
            ST_IDLE: begin
                req   = 1'b0;
                level = '0;
            end
            ST_PENDING: begin
                req   = 1'b1;
                level = LEVEL_W'(NMI_PRIORITY);
            end
        endcase
    end

    assign wake = wake_q;
endmodule

// File: rtl/nmi_edge_acceptor.sv
module nmi_edge_acceptor #(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned BLANK_CYCLES = 20,
    parameter int unsigned LEVEL_W      = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_pin,
    input  logic               edge_rise,
    input  logic               bl_override,
    input  logic               mask_all,
    input  logic               cpu_block,
    input  logic               low_power,
    input  logic               ack,
    output logic               nmi_req,
    output logic [LEVEL_W-1:0] nmi_level,
    output logic               wake_pulse
);
    logic pin_s;
    logic blank;
    logic edge_hit;

    nmi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (nmi_pin),
        .pin_sync  (pin_s)
    );

    nmi_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (edge_rise),
        .blank (blank)
    );

    nmi_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (pin_s),
        .rise_sel (edge_rise),
        .blank    (blank),
        .edge_hit (edge_hit)
    );

    nmi_accept_fsm #(.LEVEL_W(LEVEL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_hit    (edge_hit),
        .bl_override (bl_override),
        .mask_all    (mask_all),
        .cpu_block   (cpu_block),
        .low_power   (low_power),
        .ack         (ack),
        .req         (nmi_req),
        .level       (nmi_level),
        .wake        (wake_pulse)
    );
endmodule

// File: rtl/nmi_acceptor_checker.sv
module nmi_acceptor_checker #(
    parameter int unsigned BLANK_CYCLES = 20,
    parameter int unsigned LEVEL_W      = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               edge_rise,
    input logic               bl_override,
    input logic               mask_all,
    input logic               cpu_block,
    input logic               low_power,
    input logic               ack,
    input logic               nmi_req,
    input logic [LEVEL_W-1:0] nmi_level,
    input logic               wake_pulse
);
    localparam int unsigned QW = $clog2(BLANK_CYCLES + 2) + 1;

    logic          sel_seen;
    logic [QW-1:0] quiet_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_seen  <= 1'b0;
            quiet_cnt <= '1;
        end else begin
            sel_seen <= edge_rise;
            if (edge_rise != sel_seen)
                quiet_cnt <= '0;
            else if (quiet_cnt != '1)
                quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    AST_LEVEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (nmi_level == LEVEL_W'(16))) else $error("level"); // R1
    AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_req |-> (nmi_level == '0)) else $error("idle level"); // R1
    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> ($past(quiet_cnt) >= QW'(BLANK_CYCLES)
                            && $past(edge_rise) == $past(sel_seen)))
        else $error("blank"); // R3
    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> !$past(mask_all)) else $error("mask"); // R5
    AST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> $past(bl_override || !cpu_block || low_power))
        else $error("gate"); // R6
    AST_WAKE_COND: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(low_power) && !$past(mask_all) && nmi_req))
        else $error("wake"); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !ack) |=> nmi_req) else $error("hold"); // R9
endmodule

bind nmi_edge_acceptor nmi_acceptor_checker #(
    .BLANK_CYCLES (BLANK_CYCLES),
    .LEVEL_W      (LEVEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_rise   (edge_rise),
    .bl_override (bl_override),
    .mask_all    (mask_all),
    .cpu_block   (cpu_block),
    .low_power   (low_power),
    .ack         (ack),
    .nmi_req     (nmi_req),
    .nmi_level   (nmi_level),
    .wake_pulse  (wake_pulse)
);

// File: tb/tb_nmi_edge_acceptor.sv
module tb_nmi_edge_acceptor;
    localparam int CLK_PERIOD = 10;
    localparam int LW         = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          nmi_pin, edge_rise, bl_override, mask_all, cpu_block, low_power, ack;
    logic          nmi_req;
    logic [LW-1:0] nmi_level;
    logic          wake_pulse;

    int checks = 0;
    int errors = 0;
    int wake_cnt = 0;
    bit done = 1'b0;

    nmi_edge_acceptor dut (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .edge_rise(edge_rise),
        .bl_override(bl_override), .mask_all(mask_all), .cpu_block(cpu_block),
        .low_power(low_power), .ack(ack), .nmi_req(nmi_req),
        .nmi_level(nmi_level), .wake_pulse(wake_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && wake_pulse) wake_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_req();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    // drive the pin to the level that is idle for the current polarity
    task automatic pin_idle();
        nmi_pin = edge_rise ? 1'b0 : 1'b1;
    endtask

    task automatic pin_active();
        nmi_pin = edge_rise ? 1'b1 : 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; nmi_pin = 1'b0; edge_rise = 1'b1; bl_override = 1'b0;
        mask_all = 1'b0; cpu_block = 1'b0; low_power = 1'b0; ack = 1'b0;
        tick(3);
        check("R12 req in reset", int'(nmi_req), 0);
        check("R12 level in reset", int'(nmi_level), 0);
        check("R12 wake in reset", int'(wake_pulse), 0);
        rst_n = 1'b1;
        tick(1);
        check("R12 req after reset", int'(nmi_req), 0);
        tick(30);

        // R11 latency: pin driven before e1, visible after e3
        nmi_pin = 1'b1;
        tick(2);
        check("R11 not yet after two edges", int'(nmi_req), 0);
        tick(1);
        check("R11 visible after three edges", int'(nmi_req), 1);
        check("R1 level while pending", int'(nmi_level), 16);
        clear_req();
        check("R9 cleared one cycle after ack", int'(nmi_req), 0);
        check("R1 level after clear", int'(nmi_level), 0);

        // gating sweep for both polarities
        for (int pol = 1; pol >= 0; pol--) begin
            edge_rise = pol[0];
            pin_idle();
            tick(30);
            for (int c = 0; c < 16; c++) begin
                bit ma, ov, blk, lp, exp_acc, exp_wake;
                string tg;
                ma = c[3]; ov = c[2]; blk = c[1]; lp = c[0];
                mask_all = ma; bl_override = ov; cpu_block = blk; low_power = lp;
                pin_idle();
                clear_req();
                tick(5);
                check("R2/R11 wrong-direction or stale edge ignored", int'(nmi_req), 0);
                exp_acc  = !ma && (ov || !blk || lp);
                exp_wake = exp_acc && lp;
                tg = ma ? "R5 mask-all" : (lp ? "R7 low-power accept" : "R6 gate");
                wake_cnt = 0;
                pin_active();
                tick(5);
                check({tg, " R2 request"}, int'(nmi_req), int'(exp_acc));
                check("R1 level", int'(nmi_level), exp_acc ? 16 : 0);
                check("R8 wake pulse count", wake_cnt, int'(exp_wake));
                if (exp_acc) begin
                    pin_idle();   tick(4);
                    pin_active(); tick(4);
                    check("R10 still pending after second edge", int'(nmi_req), 1);
                    clear_req();
                    check("R10 one ack clears merged edges", int'(nmi_req), 0);
                    tick(3);
                    check("R10 stays clear", int'(nmi_req), 0);
                end
            end
        end

        // R9 ack in the same cycle as a new accepted edge
        mask_all = 1'b0; bl_override = 1'b1; cpu_block = 1'b0; low_power = 1'b0;
        edge_rise = 1'b1; nmi_pin = 1'b0;
        tick(30);
        nmi_pin = 1'b1; tick(3);
        check("R9 first request", int'(nmi_req), 1);
        nmi_pin = 1'b0; tick(3);
        nmi_pin = 1'b1; tick(2);
        ack = 1'b1; tick(1); ack = 1'b0;
        check("R9 edge at ack keeps pending", int'(nmi_req), 1);
        clear_req();
        check("R9 later ack clears", int'(nmi_req), 0);

        // R3 boundary: pin change driven before e18 is lost, before e19 accepted
        tick(30);
        edge_rise = ~edge_rise; pin_idle();
        tick(18); pin_active(); tick(5);
        check("R3 edge at end of window lost", int'(nmi_req), 0);
        edge_rise = ~edge_rise; pin_idle();
        tick(19); pin_active(); tick(5);
        check("R3 first edge after window accepted", int'(nmi_req), 1);
        clear_req();

        // R4 restart of the window
        tick(30);
        edge_rise = ~edge_rise; pin_idle();
        tick(15);
        edge_rise = ~edge_rise; pin_idle();
        tick(15); pin_active(); tick(5);
        check("R4 restarted window drops edge", int'(nmi_req), 0);
        pin_idle(); tick(30); pin_active(); tick(5);
        check("R4 edge after restarted window", int'(nmi_req), 1);
        clear_req();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule